// File: doc/BRIEF.md
# Readout Throttle Controller

This block decides, cycle by cycle, whether the pixel front end may keep producing hits. It watches four kinds of back-pressure: the fill level of the main hit buffer, decoded flow-control pause requests from the network receive path, a disable request raised by a neighbouring detector, and a hold requested by the host computer. When any of them is active, the front-end enable drops and the detector shutter is gated closed.

The buffer source uses two thresholds so that the throttle does not chatter around a single level. A pause request carries a 16-bit quanta count. The block holds the throttle for that count times the number of clock cycles that make up 512 bit-times on the link, and any new request replaces the running count. The host hold is latched on a busy strobe and released by a resume strobe. The block also drives a veto to the other detectors that reflects only its own local reasons for throttling. It reports which sources are active on a status vector and counts the cycles spent throttled.

Top module: `rdo_throttle_ctrl`

## Requirements
- R1: In reset and on the first cycle after it, `fe_enable` is 1, `veto_out` is 0, `status` is 0 and `throttle_cycles` is 0.
- R2: A `fifo_level` at or above `HI_MARK` sampled on a clock edge makes the buffer source active from the next cycle on.
- R3: The buffer source, once active, stays active while the sampled level is at or above `LO_MARK`. It clears on the cycle after a level below `LO_MARK` is sampled. A level in [`LO_MARK`, `HI_MARK`) never changes its state.
- R4: A `pause_req` strobe with quanta q makes the pause source active for exactly q*`CYC_PER_QUANTUM` cycles after the edge that samples it. A later strobe reloads the count, and q = 0 ends a running pause.
- R5: A `host_busy` strobe latches the host source, and a `host_resume` strobe clears it. When both are sampled on the same edge, busy wins.
- R6: `peer_disable` sampled high on an edge throttles the front end on the next cycle. It does not raise `veto_out`.
- R7: `fe_enable` is 1 exactly when no source is active.
- R8: `shutter_out` equals `shutter_in` AND `fe_enable`, with no added register.
- R9: `veto_out` is 1 exactly when the buffer, pause or host source is active.
- R10: `status` bit 0 shows the buffer source, bit 1 the pause source, bit 2 the host source and bit 3 the peer source.
- R11: `throttle_cycles` grows by one on every edge that ends a cycle with `fe_enable` low. It saturates at its all-ones value until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | LEVEL_W | Current fill level of the main hit buffer |
| pause_req | input | 1 | One-cycle strobe: a pause request was decoded |
| pause_quanta | input | 16 | Quanta count carried by the pause request |
| peer_disable | input | 1 | Disable request from another detector |
| host_busy | input | 1 | Strobe: host asks to halt readout |
| host_resume | input | 1 | Strobe: host allows readout to continue |
| shutter_in | input | 1 | Shutter request before gating |
| fe_enable | output | 1 | Front-end enable |
| shutter_out | output | 1 | Gated shutter |
| veto_out | output | 1 | Local throttle state exported to other detectors |
| status | output | 4 | Active sources {peer, host, pause, buffer} |
| throttle_cycles | output | CNT_W | Saturating count of throttled cycles |

## Verification
The bench uses an 8-bit level with marks at 200 and 64. These marks let random levels fall into all three bands: set, hold and release. It sets `CYC_PER_QUANTUM` to 2, so pauses of up to 20 quanta expire within a few dozen cycles. Reloads, zero-quanta cancels and overlaps with other sources therefore occur many times in a short run. The counter is only 6 bits wide, so saturation at 63 is reached and held between the periodic resets.

// File: rtl/rdo_throttle_pkg.sv
package rdo_throttle_pkg;

    typedef struct packed {
        logic peer;
        logic host;
        logic pause;
        logic fifo;
    } thr_src_t;

    localparam int unsigned QUANTA_W = 16;

    function automatic logic local_active(thr_src_t s);
        return s.fifo | s.pause | s.host;
    endfunction

    function automatic logic any_active(thr_src_t s);
        return local_active(s) | s.peer;
    endfunction

endpackage

// File: rtl/rdo_thr_level_hyst.sv
module rdo_thr_level_hyst #(
    parameter int unsigned LEVEL_W = 13,
    parameter int unsigned HI_MARK = 3900,
    parameter int unsigned LO_MARK = 3000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LEVEL_W-1:0] level,
    output logic               active
);
    localparam logic [LEVEL_W-1:0] HI = LEVEL_W'(HI_MARK);
    localparam logic [LEVEL_W-1:0] LO = LEVEL_W'(LO_MARK);

    logic above_hi, below_lo;
    assign above_hi = (level >= HI);
    assign below_lo = (level < LO);

    always_ff @(posedge clk) begin
        if (rst)           active <= 1'b0;
        else if (above_hi) active <= 1'b1;
        else if (below_lo) active <= 1'b0;
    end

    a_r2_set_high: assert property (@(posedge clk) disable iff (rst)
        (level >= HI) |=> active);
    a_r3_hold_band: assert property (@(posedge clk) disable iff (rst)
        (level >= LO && level < HI) |=> active == $past(active));
    a_r3_release: assert property (@(posedge clk) disable iff (rst)
        (level < LO && level < HI) |=> !active);
endmodule

// File: rtl/rdo_thr_pause_timer.sv
module rdo_thr_pause_timer
    import rdo_throttle_pkg::*;
#(
    parameter int unsigned CYC_PER_QUANTUM = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [QUANTA_W-1:0] quanta,
    output logic                active
);
    localparam int unsigned MUL_W = (CYC_PER_QUANTUM > 1) ? $clog2(CYC_PER_QUANTUM) + 1 : 1;
    localparam int unsigned CNT_W = QUANTA_W + MUL_W;

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;

    generate
        if (CYC_PER_QUANTUM == 1) begin : g_unit
            assign load_val = CNT_W'(quanta);
        end else begin : g_scaled
            assign load_val = CNT_W'(quanta) * CNT_W'(CYC_PER_QUANTUM);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                 remain <= '0;
        else if (req)            remain <= load_val;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign active = (remain != '0);

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        req |=> remain == CNT_W'($past(quanta)) * CNT_W'(CYC_PER_QUANTUM));
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (!req && remain != '0) |=> remain == $past(remain) - 1'b1);
    a_r4_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (!req && remain == '0) |=> !active);
endmodule

// File: rtl/rdo_thr_host_hold.sv
module rdo_thr_host_hold (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic resume,
    output logic hold
);
    always_ff @(posedge clk) begin
        if (rst)         hold <= 1'b0;
        else if (busy)   hold <= 1'b1;
        else if (resume) hold <= 1'b0;
    end

    a_r5_busy_sets: assert property (@(posedge clk) disable iff (rst)
        busy |=> hold);
    a_r5_resume_clears: assert property (@(posedge clk) disable iff (rst)
        (resume && !busy) |=> !hold);
    a_r5_quiet_keeps: assert property (@(posedge clk) disable iff (rst)
        (!resume && !busy) |=> hold == $past(hold));
endmodule

// File: rtl/rdo_throttle_ctrl.sv
module rdo_throttle_ctrl
    import rdo_throttle_pkg::*;
#(
    parameter int unsigned LEVEL_W         = 13,
    parameter int unsigned HI_MARK         = 3900,
    parameter int unsigned LO_MARK         = 3000,
    parameter int unsigned CYC_PER_QUANTUM = 8,
    parameter int unsigned CNT_W           = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LEVEL_W-1:0]  fifo_level,
    input  logic                pause_req,
    input  logic [15:0]         pause_quanta,
    input  logic                peer_disable,
    input  logic                host_busy,
    input  logic                host_resume,
    input  logic                shutter_in,
    output logic                fe_enable,
    output logic                shutter_out,
    output logic                veto_out,
    output logic [3:0]          status,
    output logic [CNT_W-1:0]    throttle_cycles
);
    thr_src_t src;
    logic     fifo_act, pause_act, host_act, peer_q;
    logic     throttled;

    rdo_thr_level_hyst #(
        .LEVEL_W (LEVEL_W),
        .HI_MARK (HI_MARK),
        .LO_MARK (LO_MARK)
    ) u_level (
        .clk    (clk),
        .rst    (rst),
        .level  (fifo_level),
        .active (fifo_act)
    );

    rdo_thr_pause_timer #(
        .CYC_PER_QUANTUM (CYC_PER_QUANTUM)
    ) u_pause (
        .clk    (clk),
        .rst    (rst),
        .req    (pause_req),
        .quanta (pause_quanta),
        .active (pause_act)
    );

    rdo_thr_host_hold u_host (
        .clk    (clk),
        .rst    (rst),
        .busy   (host_busy),
        .resume (host_resume),
        .hold   (host_act)
    );

    always_ff @(posedge clk) begin
        if (rst) peer_q <= 1'b0;
        else     peer_q <= peer_disable;
    end

    always_comb begin
        src.fifo  = fifo_act;
        src.pause = pause_act;
        src.host  = host_act;
        src.peer  = peer_q;
    end

    assign throttled   = any_active(src);
    assign fe_enable   = ~throttled;
    assign veto_out    = local_active(src);
    assign shutter_out = shutter_in & fe_enable;
    assign status      = src;

    always_ff @(posedge clk) begin
        if (rst)
            throttle_cycles <= '0;
        else if (throttled && throttle_cycles != '1)
            throttle_cycles <= throttle_cycles + 1'b1;
    end

    a_r6_peer_throttles: assert property (@(posedge clk) disable iff (rst)
        peer_disable |=> !fe_enable);
    a_r7_enable_when_clear: assert property (@(posedge clk) disable iff (rst)
        (!fifo_act && !pause_act && !host_act && !peer_q) |-> fe_enable);
    a_r8_shutter_gated: assert property (@(posedge clk) disable iff (rst)
        !fe_enable |-> !shutter_out);
    a_r9_veto_local: assert property (@(posedge clk) disable iff (rst)
        veto_out |-> (fifo_act || pause_act || host_act));
    a_r11_counts: assert property (@(posedge clk) disable iff (rst)
        (!fe_enable && throttle_cycles != '1) |=> throttle_cycles == $past(throttle_cycles) + 1'b1);
    a_r11_saturates: assert property (@(posedge clk) disable iff (rst)
        (throttle_cycles == '1) |=> throttle_cycles == '1);
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        fe_enable |=> $stable(throttle_cycles));
endmodule

// File: tb/rdo_throttle_ctrl_tb.sv
module rdo_throttle_ctrl_tb;
    localparam int unsigned LEVEL_W = 8;
    localparam int unsigned HI      = 200;
    localparam int unsigned LO      = 64;
    localparam int unsigned CYC     = 2;
    localparam int unsigned CW      = 6;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [LEVEL_W-1:0] fifo_level = '0;
    logic               pause_req = 1'b0;
    logic [15:0]        pause_quanta = '0;
    logic               peer_disable = 1'b0;
    logic               host_busy = 1'b0;
    logic               host_resume = 1'b0;
    logic               shutter_in = 1'b0;
    logic               fe_enable, shutter_out, veto_out;
    logic [3:0]         status;
    logic [CW-1:0]      throttle_cycles;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    rdo_throttle_ctrl #(
        .LEVEL_W (LEVEL_W), .HI_MARK (HI), .LO_MARK (LO),
        .CYC_PER_QUANTUM (CYC), .CNT_W (CW)
    ) u_dut (
        .clk (clk), .rst (rst), .fifo_level (fifo_level),
        .pause_req (pause_req), .pause_quanta (pause_quanta),
        .peer_disable (peer_disable), .host_busy (host_busy),
        .host_resume (host_resume), .shutter_in (shutter_in),
        .fe_enable (fe_enable), .shutter_out (shutter_out),
        .veto_out (veto_out), .status (status),
        .throttle_cycles (throttle_cycles)
    );

    // Reference state, built from the requirements
    logic        m_fifo, m_host, m_peer;
    int unsigned m_remain, m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_fifo <= 0; m_host <= 0; m_peer <= 0; m_remain <= 0; m_cnt <= 0;
        end else begin
            if (fifo_level >= HI)     m_fifo <= 1;          // R2
            else if (fifo_level < LO) m_fifo <= 0;          // R3
            if (pause_req)            m_remain <= pause_quanta * CYC; // R4
            else if (m_remain != 0)   m_remain <= m_remain - 1;
            if (host_busy)            m_host <= 1;          // R5
            else if (host_resume)     m_host <= 0;
            m_peer <= peer_disable;                         // R6
            if (exp_status() != 0 && m_cnt < (1 << CW) - 1) m_cnt <= m_cnt + 1; // R11
        end
    end

    function automatic logic [3:0] exp_status();
        return {m_peer, m_host, (m_remain != 0), m_fifo};
    endfunction

    task automatic chk(string req, int unsigned act, int unsigned exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [3:0] st = exp_status();
        logic en = (st == 0);
        chk("R10 status", status, st);
        chk("R7 fe_enable", fe_enable, en);
        chk("R9 veto", veto_out, |st[2:0]);
        chk("R8 shutter", shutter_out, shutter_in & en);
        chk("R11 counter", throttle_cycles, m_cnt);
    endtask

    task automatic clear_strobes();
        pause_req = 0; host_busy = 0; host_resume = 0;
    endtask

    // one cycle: check state, then apply new inputs via caller
    task automatic tick();
        @(negedge clk);
        check_all();
        clear_strobes();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        clear_strobes();
        fifo_level = 0; peer_disable = 0;
        @(negedge clk);
        rst = 0;
    endtask

    initial begin : main
        int dur;
        void'($urandom(32'hC0FFEE));
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 fe_enable", fe_enable, 1);
        chk("R1 veto", veto_out, 0);
        chk("R1 status", status, 0);
        chk("R1 counter", throttle_cycles, 0);
        shutter_in = 1;

        // R2/R3 hysteresis boundaries
        fifo_level = LEVEL_W'(HI - 1); tick();
        chk("R2 below HI no throttle", status[0], 0);
        fifo_level = LEVEL_W'(HI); tick();
        chk("R2 at HI throttles", status[0], 1);
        fifo_level = LEVEL_W'(LO); tick(); tick();
        chk("R3 at LO still held", status[0], 1);
        fifo_level = LEVEL_W'(LO - 1); tick();
        chk("R3 below LO releases", status[0], 0);
        fifo_level = LEVEL_W'(HI - 1); tick(); tick();
        chk("R3 band keeps clear", status[0], 0);
        fifo_level = 0;

        // R4 exact pause duration
        tick();
        pause_req = 1; pause_quanta = 3;
        dur = 0;
        tick();
        while (status[1] && dur < 100) begin dur++; tick(); end
        chk("R4 pause length", dur, 3 * CYC);
        // R4 reload and zero cancel
        pause_req = 1; pause_quanta = 10; tick();
        tick();
        pause_req = 1; pause_quanta = 0; tick();
        chk("R4 zero quanta ends pause", status[1], 0);

        // R5 host hold, set wins
        host_busy = 1; tick();
        chk("R5 busy latches", status[2], 1);
        tick(); tick();
        chk("R5 hold persists", status[2], 1);
        host_busy = 1; host_resume = 1; tick();
        chk("R5 busy wins over resume", status[2], 1);
        host_resume = 1; tick();
        chk("R5 resume clears", status[2], 0);

        // R6 peer: throttles but no veto
        peer_disable = 1; tick();
        chk("R6 peer throttles", fe_enable, 0);
        chk("R6 peer no veto", veto_out, 0);
        peer_disable = 0; tick();
        chk("R6 peer released", fe_enable, 1);

        // R11 saturation: hold throttle long
        peer_disable = 1;
        repeat (80) tick();
        chk("R11 saturated", throttle_cycles, (1 << CW) - 1);
        peer_disable = 0;

        // random phase
        for (int i = 0; i < 4000; i++) begin
            tick();
            if (i % 500 == 499) begin
                do_reset();
                @(negedge clk);
                chk("R1 counter after reset", throttle_cycles, 0);
                chk("R1 enable after reset", fe_enable, 1);
                continue;
            end
            if ($urandom % 8 == 0)  fifo_level = LEVEL_W'($urandom);
            if ($urandom % 40 == 0) begin pause_req = 1; pause_quanta = 16'($urandom % 20); end
            if ($urandom % 50 == 0) host_busy = 1;
            if ($urandom % 30 == 0) host_resume = 1;
            if ($urandom % 30 == 0) peer_disable = ~peer_disable;
            shutter_in = 1'($urandom);
        end
        tick();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule